// File: doc/BRIEF.md
# Linked-List Context Save/Restore Engine

This block moves a processor's register context between the register file and memory. Memory holds a pool of 64-byte frames chained into a free list. Each link is a 20-bit packed segment/offset value. The engine keeps three registers: the free-list head, the link to the most recently saved context, and a limit link that marks the last frame which may be taken safely.

A call or an interrupt entry takes the frame at the head of the free list and reads its first word as the new head. It then writes sixteen words into the frame and chains the frame onto the saved-context list. A call stores the upper bank and an interrupt entry stores the lower bank. A return or a return-from-exception walks the list the other way: it reloads the upper bank from the frame the link points to, puts that frame back on the free list and restores the previous link. The register file is reached through a single-word port with slot numbers. Memory is reached through a request/acknowledge port that moves one word per acknowledge.

Top module: `ctx_engine`

## Requirements
- R1: With the engine idle, command code 1 (setup) loads the head, link and limit registers from `cfgHead`, `cfgLink` and `cfgLimit` on the accepting edge. Busy is not raised. `headOut` and `linkOut` show the new values.
- R2: A call (code 2) or an interrupt entry (code 4) with head bits 19:0 equal to zero completes with `errUnderflow` high alongside `done`. It makes no memory access and leaves head, link and registers unchanged.
- R3: A link L maps to frame address {L[19:16], 6'b0, L[15:0], 6'b0}. A save first reads the word at the frame address and then writes frame words 0 to 15 at byte offsets 0 to 60 in rising order. Each word moves on one edge where `memReq` and `memAck` are both high. Request, direction and address hold steady while the acknowledge is low.
- R4: Frame word 0 of a save is the link register. Word k (1 to 15) is register-file slot k: the upper bank (`rfUpper`=1) on a call and the lower bank on an interrupt entry. Slot 3 of the upper bank is the return address.
- R5: After a successful save, link = {priority[31:24], enable[23], tag[22], old link[21:20], old head[19:0]}. The priority and enable are the values of `curPrio` and `curIe` when the command was accepted. The tag is 1 for a call and 0 for an interrupt entry. Head bits 19:0 take the fetched word's bits 19:0. A call writes `cmdPc` into upper slot 3. An interrupt entry loads priority `cmdPrio` with enable 1 through `prioLoad`.
- R6: If head bits 19:0 equal limit bits 19:0 when a save begins, `errDepleted` is high alongside `done`, and the save still completes in full.
- R7: A return (code 3) or a return-from-exception (code 5) raises `errNoCtx` if link bits 19:0 are zero and `errType` if link bit 22 is zero. Each flag is reported alongside `done`. When either is raised there is no memory access and no state change.
- R8: A successful return sets `retPc` to upper slot 3 with bit 0 cleared. It reads frame words 0 to 15 from the link's frame and writes words 1 to 15 into upper slots 1 to 15. It then writes the head register to frame word 0. Afterwards head bits 19:0 equal the old link bits 19:0 and the link equals the word 0 that was read.
- R9: A return-from-exception loads priority from link bits 31:24 and enable from link bit 23 through `prioLoad` before its first memory request.
- R10: Busy is high from the edge that accepts a command until the cycle after the one-cycle `done` pulse. Commands presented while busy, including setup, have no effect.
- R11: Head bits 31:20 change only on setup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmdValid | input | 1 | Command present |
| cmdOp | input | 3 | 1 setup, 2 call, 3 return, 4 interrupt entry, 5 return-from-exception |
| cmdPc | input | 32 | Return address stored by a call |
| cmdPrio | input | 8 | Priority set by an interrupt entry |
| cfgHead | input | 32 | Head value for setup |
| cfgLink | input | 32 | Link value for setup |
| cfgLimit | input | 32 | Limit value for setup |
| curPrio | input | 8 | Current priority |
| curIe | input | 1 | Current interrupt enable |
| busy | output | 1 | Command in progress |
| done | output | 1 | Completion pulse |
| errUnderflow | output | 1 | Free list empty (with done) |
| errDepleted | output | 1 | Limit frame taken (with done) |
| errNoCtx | output | 1 | No saved context (with done) |
| errType | output | 1 | Saved frame is not upper type (with done) |
| retPc | output | 32 | Return target of a return |
| headOut | output | 32 | Free-list head register |
| linkOut | output | 32 | Saved-context link register |
| memReq | output | 1 | Memory word request |
| memWe | output | 1 | Request is a write |
| memAddr | output | 32 | Byte address |
| memWdata | output | 32 | Write data |
| memAck | input | 1 | Word transferred on this edge |
| memRdata | input | 32 | Read data, valid with memAck |
| rfUpper | output | 1 | Register bank select, 1 = upper |
| rfSlot | output | 4 | Register slot |
| rfRdata | input | 32 | Register read data |
| rfWe | output | 1 | Register write |
| rfWdata | output | 32 | Register write data |
| prioLoad | output | 1 | Load priority and enable |
| prioNew | output | 8 | Priority to load |
| ieNew | output | 1 | Enable to load |

## Verification
The limit check and the completion of a save land in the same cycle: `errDepleted` must rise with `done` while all sixteen writes still happen. The bench provokes this by setting the limit to the second frame of the list and issuing two calls. The first must finish clean and the second must finish with the flag high, a full frame written and the head advanced. The bench also presents a setup and a call during a return that is slowed by acknowledge stalls. It judges them by checking that the word sequence and the resulting head, link and registers match a return alone.

// File: rtl/ctx_pkg.sv
package ctx_pkg;
  typedef enum logic [2:0] {
    OP_NONE    = 3'd0,
    OP_SETUP   = 3'd1,
    OP_CALL    = 3'd2,
    OP_RET     = 3'd3,
    OP_INTSAVE = 3'd4,
    OP_RFE     = 3'd5
  } ctxOpE;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CHECK, ST_FETCH, ST_SAVE, ST_LOAD, ST_FREE, ST_FIN
  } ctxStateE;

  typedef struct packed {
    logic setup;
    logic capture;
    logic capPc;
    logic restorePrio;
    logic ldNext;
    logic ldNewLink;
    logic wrHead;
    logic writeRa;
    logic saveWord0;
    logic addrFromLink;
    logic tagUpper;
    logic intPrio;
    logic commitSave;
    logic commitRestore;
  } ctxStrobeT;
endpackage

// File: rtl/ctx_ctrl.sv
module ctx_ctrl
  import ctx_pkg::*;
#(
  parameter int WORDS   = 16,
  parameter int RA_SLOT = 3,
  localparam int IDX_W  = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmdValid,
  input  ctxOpE            cmdOp,
  input  logic             headZero,
  input  logic             linkZero,
  input  logic             linkTag,
  input  logic             memAck,
  output ctxStrobeT        st,
  output logic [IDX_W-1:0] wordIdx,
  output logic             busy,
  output logic             done,
  output logic             memReq,
  output logic             memWe,
  output logic             rfUpper,
  output logic             rfWe,
  output logic [IDX_W-1:0] rfSlot,
  output logic             errUnder,
  output logic             errNoCtx,
  output logic             errType
);
  ctxStateE stateQ, nxtState;
  ctxOpE    opQ;
  logic [IDX_W-1:0] idxQ;
  logic errUnderQ, errNoCtxQ, errTypeQ;
  logic isSave, lastIdx, aborted, cmdWork;

  assign isSave  = (opQ == OP_CALL) || (opQ == OP_INTSAVE);
  assign lastIdx = (idxQ == IDX_W'(WORDS - 1));
  assign aborted = errUnderQ | errNoCtxQ | errTypeQ;
  assign cmdWork = (cmdOp == OP_CALL) || (cmdOp == OP_RET) ||
                   (cmdOp == OP_INTSAVE) || (cmdOp == OP_RFE);

  always_comb begin
    st       = '0;
    nxtState = stateQ;
    memReq   = 1'b0;
    memWe    = 1'b0;
    rfWe     = 1'b0;
    rfSlot   = idxQ;
    done     = 1'b0;
    st.addrFromLink = (stateQ == ST_LOAD) || (stateQ == ST_FREE);
    st.tagUpper     = (opQ == OP_CALL);
    case (stateQ)
      ST_IDLE: begin
        if (cmdValid) begin
          if (cmdOp == OP_SETUP) begin
            st.setup = 1'b1;
          end else if (cmdWork) begin
            st.capture = 1'b1;
            nxtState   = ST_CHECK;
          end
        end
      end
      ST_CHECK: begin
        if (isSave) begin
          nxtState = headZero ? ST_FIN : ST_FETCH;
        end else if (linkZero || !linkTag) begin
          nxtState = ST_FIN;
        end else begin
          st.capPc       = 1'b1;
          rfSlot         = IDX_W'(RA_SLOT);
          st.restorePrio = (opQ == OP_RFE);
          nxtState       = ST_LOAD;
        end
      end
      ST_FETCH: begin
        memReq = 1'b1;
        if (memAck) begin
          st.ldNext = 1'b1;
          nxtState  = ST_SAVE;
        end
      end
      ST_SAVE: begin
        memReq       = 1'b1;
        memWe        = 1'b1;
        st.saveWord0 = (idxQ == '0);
        if (memAck && lastIdx) nxtState = ST_FIN;
      end
      ST_LOAD: begin
        memReq = 1'b1;
        if (memAck) begin
          if (idxQ == '0) st.ldNewLink = 1'b1;
          else            rfWe         = 1'b1;
          if (lastIdx) nxtState = ST_FREE;
        end
      end
      ST_FREE: begin
        memReq    = 1'b1;
        memWe     = 1'b1;
        st.wrHead = 1'b1;
        if (memAck) nxtState = ST_FIN;
      end
      ST_FIN: begin
        done     = 1'b1;
        nxtState = ST_IDLE;
        if (!aborted) begin
          st.commitSave    = isSave;
          st.commitRestore = !isSave;
          st.intPrio       = (opQ == OP_INTSAVE);
          if (opQ == OP_CALL) begin
            st.writeRa = 1'b1;
            rfWe       = 1'b1;
            rfSlot     = IDX_W'(RA_SLOT);
          end
        end
      end
      default: nxtState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stateQ    <= ST_IDLE;
      opQ       <= OP_NONE;
      idxQ      <= '0;
      errUnderQ <= 1'b0;
      errNoCtxQ <= 1'b0;
      errTypeQ  <= 1'b0;
    end else begin
      stateQ <= nxtState;
      if (st.capture) begin
        opQ       <= cmdOp;
        idxQ      <= '0;
        errUnderQ <= 1'b0;
        errNoCtxQ <= 1'b0;
        errTypeQ  <= 1'b0;
      end
      if (stateQ == ST_CHECK) begin
        errUnderQ <= isSave & headZero;
        errNoCtxQ <= !isSave & linkZero;
        errTypeQ  <= !isSave & !linkTag;
      end
      if (memAck && ((stateQ == ST_SAVE) || (stateQ == ST_LOAD))) begin
        idxQ <= lastIdx ? '0 : idxQ + 1'b1;
      end
    end
  end

  assign wordIdx  = idxQ;
  assign busy     = (stateQ != ST_IDLE);
  assign rfUpper  = (opQ != OP_INTSAVE);
  assign errUnder = done & errUnderQ;
  assign errNoCtx = done & errNoCtxQ;
  assign errType  = done & errTypeQ;

  AST_FETCH_HEAD_NONZERO: assert property (@(posedge clk) disable iff (rst)
    (stateQ == ST_FETCH) |-> !headZero); // R2
  AST_LOAD_LINK_VALID: assert property (@(posedge clk) disable iff (rst)
    (stateQ == ST_LOAD) |-> (!linkZero && linkTag)); // R7
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R10
endmodule

// File: rtl/ctx_dp.sv
module ctx_dp
  import ctx_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LINK_W = 20,
  parameter int OFF_W  = 16,
  parameter int PRIO_W = 8,
  parameter int IDX_W  = 4,
  localparam int GAP_W = DATA_W - LINK_W - IDX_W - 2,
  localparam int IE_B  = DATA_W - PRIO_W - 1,
  localparam int TAG_B = IE_B - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  ctxStrobeT         st,
  input  logic [IDX_W-1:0]  wordIdx,
  input  logic [DATA_W-1:0] cfgHead,
  input  logic [DATA_W-1:0] cfgLink,
  input  logic [DATA_W-1:0] cfgLimit,
  input  logic [PRIO_W-1:0] curPrio,
  input  logic              curIe,
  input  logic [PRIO_W-1:0] cmdPrio,
  input  logic [DATA_W-1:0] cmdPc,
  input  logic [DATA_W-1:0] memRdata,
  input  logic [DATA_W-1:0] rfRdata,
  output logic [DATA_W-1:0] headOut,
  output logic [DATA_W-1:0] linkOut,
  output logic [DATA_W-1:0] retPc,
  output logic [DATA_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic [DATA_W-1:0] rfWdata,
  output logic              prioLoad,
  output logic [PRIO_W-1:0] prioNew,
  output logic              ieNew,
  output logic              headZero,
  output logic              linkZero,
  output logic              linkTag,
  output logic              limitHit
);
  logic [DATA_W-1:0] headQ, linkQ, limitQ, newLinkQ, pcQ, nextPcQ;
  logic [LINK_W-1:0] nextQ, base;
  logic [PRIO_W-1:0] prioQ, argPrioQ;
  logic              ieQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      headQ    <= '0;
      linkQ    <= '0;
      limitQ   <= '0;
      newLinkQ <= '0;
      pcQ      <= '0;
      nextPcQ  <= '0;
      nextQ    <= '0;
      prioQ    <= '0;
      argPrioQ <= '0;
      ieQ      <= 1'b0;
    end else begin
      if (st.setup) begin
        headQ  <= cfgHead;
        linkQ  <= cfgLink;
        limitQ <= cfgLimit;
      end
      if (st.capture) begin
        prioQ    <= curPrio;
        ieQ      <= curIe;
        argPrioQ <= cmdPrio;
        nextPcQ  <= cmdPc;
      end
      if (st.capPc)     pcQ      <= {rfRdata[DATA_W-1:1], 1'b0};
      if (st.ldNext)    nextQ    <= memRdata[LINK_W-1:0];
      if (st.ldNewLink) newLinkQ <= memRdata;
      if (st.commitSave) begin
        linkQ <= {prioQ, ieQ, st.tagUpper, linkQ[TAG_B-1:LINK_W], headQ[LINK_W-1:0]};
        headQ[LINK_W-1:0] <= nextQ;
      end
      if (st.commitRestore) begin
        headQ[LINK_W-1:0] <= linkQ[LINK_W-1:0];
        linkQ             <= newLinkQ;
      end
    end
  end

  assign base     = st.addrFromLink ? linkQ[LINK_W-1:0] : headQ[LINK_W-1:0];
  assign memAddr  = {base[LINK_W-1:OFF_W], {GAP_W{1'b0}}, base[OFF_W-1:0], wordIdx, 2'b00};
  assign memWdata = st.wrHead ? headQ : (st.saveWord0 ? linkQ : rfRdata);
  assign rfWdata  = st.writeRa ? nextPcQ : memRdata;
  assign prioLoad = st.restorePrio | st.intPrio;
  assign prioNew  = st.restorePrio ? linkQ[DATA_W-1 -: PRIO_W] : argPrioQ;
  assign ieNew    = st.restorePrio ? linkQ[IE_B] : 1'b1;
  assign headZero = (headQ[LINK_W-1:0] == '0);
  assign linkZero = (linkQ[LINK_W-1:0] == '0);
  assign linkTag  = linkQ[TAG_B];
  assign limitHit = (headQ[LINK_W-1:0] == limitQ[LINK_W-1:0]);
  assign headOut  = headQ;
  assign linkOut  = linkQ;
  assign retPc    = pcQ;

  AST_HEAD_UPPER_KEEP: assert property (@(posedge clk) disable iff (rst)
    !st.setup |=> $stable(headQ[DATA_W-1:LINK_W])); // R11
endmodule

// File: rtl/ctx_engine.sv
module ctx_engine
  import ctx_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int LINK_W  = 20,
  parameter int OFF_W   = 16,
  parameter int PRIO_W  = 8,
  parameter int WORDS   = 16,
  parameter int RA_SLOT = 3,
  localparam int IDX_W  = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmdValid,
  input  logic [2:0]        cmdOp,
  input  logic [DATA_W-1:0] cmdPc,
  input  logic [PRIO_W-1:0] cmdPrio,
  input  logic [DATA_W-1:0] cfgHead,
  input  logic [DATA_W-1:0] cfgLink,
  input  logic [DATA_W-1:0] cfgLimit,
  input  logic [PRIO_W-1:0] curPrio,
  input  logic              curIe,
  output logic              busy,
  output logic              done,
  output logic              errUnderflow,
  output logic              errDepleted,
  output logic              errNoCtx,
  output logic              errType,
  output logic [DATA_W-1:0] retPc,
  output logic [DATA_W-1:0] headOut,
  output logic [DATA_W-1:0] linkOut,
  output logic              memReq,
  output logic              memWe,
  output logic [DATA_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic              memAck,
  input  logic [DATA_W-1:0] memRdata,
  output logic              rfUpper,
  output logic [IDX_W-1:0]  rfSlot,
  input  logic [DATA_W-1:0] rfRdata,
  output logic              rfWe,
  output logic [DATA_W-1:0] rfWdata,
  output logic              prioLoad,
  output logic [PRIO_W-1:0] prioNew,
  output logic              ieNew
);
  ctxStrobeT        st;
  logic [IDX_W-1:0] wordIdx;
  logic headZero, linkZero, linkTag, limitHit;

  ctx_ctrl #(.WORDS(WORDS), .RA_SLOT(RA_SLOT)) u_ctrl (
    .clk(clk), .rst(rst), .cmdValid(cmdValid), .cmdOp(ctxOpE'(cmdOp)),
    .headZero(headZero), .linkZero(linkZero), .linkTag(linkTag), .memAck(memAck),
    .st(st), .wordIdx(wordIdx), .busy(busy), .done(done),
    .memReq(memReq), .memWe(memWe), .rfUpper(rfUpper), .rfWe(rfWe), .rfSlot(rfSlot),
    .errUnder(errUnderflow), .errNoCtx(errNoCtx), .errType(errType)
  );

  ctx_dp #(.DATA_W(DATA_W), .LINK_W(LINK_W), .OFF_W(OFF_W), .PRIO_W(PRIO_W),
           .IDX_W(IDX_W)) u_dp (
    .clk(clk), .rst(rst), .st(st), .wordIdx(wordIdx),
    .cfgHead(cfgHead), .cfgLink(cfgLink), .cfgLimit(cfgLimit),
    .curPrio(curPrio), .curIe(curIe), .cmdPrio(cmdPrio), .cmdPc(cmdPc),
    .memRdata(memRdata), .rfRdata(rfRdata),
    .headOut(headOut), .linkOut(linkOut), .retPc(retPc),
    .memAddr(memAddr), .memWdata(memWdata), .rfWdata(rfWdata),
    .prioLoad(prioLoad), .prioNew(prioNew), .ieNew(ieNew),
    .headZero(headZero), .linkZero(linkZero), .linkTag(linkTag), .limitHit(limitHit)
  );

  assign errDepleted = st.commitSave & limitHit;

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (memReq && !memAck) |=> (memReq && $stable(memAddr) && $stable(memWe))); // R3
  AST_DEPLETE_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
    errDepleted |-> done); // R6
endmodule

// File: tb/ctx_engine_tb.sv
module ctx_engine_tb;
  localparam logic [2:0] C_SETUP = 3'd1, C_CALL = 3'd2, C_RET = 3'd3, C_INT = 3'd4, C_RFE = 3'd5;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst, cmdValid, curIe, busy, done, errUnderflow, errDepleted, errNoCtx, errType;
  logic [2:0] cmdOp;
  logic [31:0] cmdPc, cfgHead, cfgLink, cfgLimit, retPc, headOut, linkOut;
  logic [7:0] cmdPrio, curPrio, prioNew;
  logic memReq, memWe, memAck, rfUpper, rfWe, prioLoad, ieNew;
  logic [31:0] memAddr, memWdata, memRdata, rfRdata, rfWdata;
  logic [3:0] rfSlot;

  ctx_engine u_dut (.*);

  logic [31:0] rfUp [16];
  logic [31:0] rfLo [16];
  logic [31:0] mem [logic [31:0]];
  logic [31:0] qAddr [$];
  logic [31:0] qData [$];
  logic        qWe [$];
  logic [15:0] lfsr;
  logic        ackRandom;
  int nChecks = 0, nFail = 0;

  function automatic logic [31:0] frameOf(logic [19:0] l);
    return {l[19:16], 6'b0, l[15:0], 6'b0};
  endfunction

  function automatic logic [31:0] memRd(logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  task automatic chkEq(string req, string what, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  assign curPrio = prioReg;
  assign curIe   = ieReg;
  logic [7:0] prioReg;
  logic       ieReg;

  always_comb rfRdata = rfUpper ? rfUp[rfSlot] : rfLo[rfSlot];

  always @(posedge clk) begin
    if (rst) begin
      prioReg <= 8'h10;
      ieReg   <= 1'b0;
    end else begin
      if (prioLoad) begin
        prioReg <= prioNew;
        ieReg   <= ieNew;
      end
      if (rfWe) begin
        if (rfUpper) rfUp[rfSlot] <= rfWdata;
        else         rfLo[rfSlot] <= rfWdata;
      end
      if (memReq && memAck) begin
        if (qAddr.size() == 0) begin
          chkEq("R3", "unexpected transfer addr", memAddr, 32'hFFFF_FFFF);
        end else begin
          logic [31:0] ea, ed;
          logic ew;
          ea = qAddr.pop_front();
          ed = qData.pop_front();
          ew = qWe.pop_front();
          chkEq("R3", "transfer address", memAddr, ea);
          chkEq("R3", "transfer direction", {31'b0, memWe}, {31'b0, ew});
          if (ew) chkEq("R4", "write data", memWdata, ed);
        end
        if (memWe) mem[memAddr] = memWdata;
      end
    end
  end

  always @(negedge clk) begin
    lfsr     <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    memAck   <= memReq && (!ackRandom || lfsr[0]);
    memRdata <= (memReq && !memWe) ? memRd(memAddr) : 32'h0;
  end

  logic [31:0] mHead, mLink, mLimit;

  task automatic fillRegs(int seed);
    for (int i = 0; i < 16; i++) begin
      rfUp[i] <= 32'hC000_0000 + seed * 32'h100 + i;
      rfLo[i] <= 32'h3000_0000 + seed * 32'h100 + i;
    end
    @(negedge clk);
  endtask

  task automatic push(logic we, logic [31:0] a, logic [31:0] d);
    qWe.push_back(we);
    qAddr.push_back(a);
    qData.push_back(d);
  endtask

  task automatic doCmd(logic [2:0] op, logic [31:0] pc, logic [7:0] prio, bit inject, string tag);
    logic [31:0] expUp [16];
    logic [31:0] expLo [16];
    logic [31:0] base, ePc, nl;
    logic [7:0]  ePrio;
    logic        eIe, eUnder, eDepl, eNoCtx, eType;
    bit          isSave, restoreOk;
    int n;
    for (int i = 0; i < 16; i++) begin
      expUp[i] = rfUp[i];
      expLo[i] = rfLo[i];
    end
    ePrio = prioReg; eIe = ieReg;
    eUnder = 0; eDepl = 0; eNoCtx = 0; eType = 0; ePc = 32'h0; restoreOk = 0;
    isSave = (op == C_CALL) || (op == C_INT);
    if (isSave) begin
      if (mHead[19:0] == 20'h0) eUnder = 1;
      else begin
        base = frameOf(mHead[19:0]);
        push(1'b0, base, 32'h0);
        for (int i = 0; i < 16; i++)
          push(1'b1, base + 4 * i, (i == 0) ? mLink : ((op == C_CALL) ? rfUp[i] : rfLo[i]));
        nl = memRd(base);
        eDepl = (mHead[19:0] == mLimit[19:0]);
        mLink = {prioReg, ieReg, (op == C_CALL), mLink[21:20], mHead[19:0]};
        mHead = {mHead[31:20], nl[19:0]};
        if (op == C_CALL) expUp[3] = pc;
        else begin ePrio = prio; eIe = 1'b1; end
      end
    end else begin
      eNoCtx = (mLink[19:0] == 20'h0);
      eType  = !mLink[22];
      if (!eNoCtx && !eType) begin
        restoreOk = 1;
        ePc = {rfUp[3][31:1], 1'b0};
        if (op == C_RFE) begin ePrio = mLink[31:24]; eIe = mLink[23]; end
        base = frameOf(mLink[19:0]);
        for (int i = 0; i < 16; i++) begin
          push(1'b0, base + 4 * i, 32'h0);
          if (i > 0) expUp[i] = memRd(base + 4 * i);
        end
        push(1'b1, base, mHead);
        nl = memRd(base);
        mHead = {mHead[31:20], mLink[19:0]};
        mLink = nl;
      end
    end
    cmdValid = 1'b1; cmdOp = op; cmdPc = pc; cmdPrio = prio;
    @(negedge clk);
    cmdValid = 1'b0;
    chkEq("R10", {tag, " busy after accept"}, {31'b0, busy}, 32'h1);
    if (inject) begin
      @(negedge clk);
      cmdValid = 1'b1; cmdOp = C_SETUP;
      cfgHead = 32'h1111_1111; cfgLink = 32'h2222_2222; cfgLimit = 32'h3333_3333;
      @(negedge clk);
      cmdOp = C_CALL;
      @(negedge clk);
      cmdValid = 1'b0;
    end
    n = 0;
    while (!done && n < 2000) begin @(negedge clk); n++; end
    chkEq("R10", {tag, " done seen"}, {31'b0, done}, 32'h1);
    chkEq("R2", {tag, " underflow flag"}, {31'b0, errUnderflow}, {31'b0, eUnder});
    chkEq("R6", {tag, " depleted flag"}, {31'b0, errDepleted}, {31'b0, eDepl});
    chkEq("R7", {tag, " no-context flag"}, {31'b0, errNoCtx}, {31'b0, eNoCtx});
    chkEq("R7", {tag, " type flag"}, {31'b0, errType}, {31'b0, eType});
    if (restoreOk) chkEq("R8", {tag, " return pc"}, retPc, ePc);
    @(negedge clk);
    chkEq("R10", {tag, " idle after done"}, {31'b0, busy}, 32'h0);
    chkEq("R5", {tag, " head register"}, headOut, mHead);
    chkEq("R8", {tag, " link register"}, linkOut, mLink);
    chkEq("R11", {tag, " head upper bits"}, {20'h0, headOut[31:20]}, {20'h0, mHead[31:20]});
    chkEq("R3", {tag, " pending transfers"}, qAddr.size(), 32'h0);
    chkEq("R9", {tag, " priority"}, {24'h0, prioReg}, {24'h0, ePrio});
    chkEq("R9", {tag, " enable"}, {31'b0, ieReg}, {31'b0, eIe});
    for (int i = 1; i < 16; i++) begin
      chkEq("R4", {tag, " upper slot"}, rfUp[i], expUp[i]);
      chkEq("R8", {tag, " lower slot"}, rfLo[i], expLo[i]);
    end
    qAddr.delete(); qData.delete(); qWe.delete();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL R10 watchdog actual=%h expected=%h", 32'h1, 32'h0);
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    rst = 1'b1; cmdValid = 1'b0; cmdOp = 3'd0; cmdPc = '0; cmdPrio = '0;
    cfgHead = '0; cfgLink = '0; cfgLimit = '0; lfsr = 16'hACE1; ackRandom = 1'b0;
    mHead = '0; mLink = '0; mLimit = '0;
    mem[frameOf(20'h1_0010)] = 32'h0000_0000 | 20'h1_0011;
    mem[frameOf(20'h1_0011)] = 32'h0000_0000 | 20'h2_0005;
    mem[frameOf(20'h2_0005)] = 32'h0000_0000 | 20'h2_0006;
    mem[frameOf(20'h2_0006)] = 32'h0;
    fillRegs(1);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // reset state (R1, R10)
    chkEq("R10", "reset busy", {31'b0, busy}, 32'h0);
    chkEq("R10", "reset done", {31'b0, done}, 32'h0);
    chkEq("R1", "reset head", headOut, 32'h0);
    chkEq("R1", "reset link", linkOut, 32'h0);
    chkEq("R3", "reset request", {31'b0, memReq}, 32'h0);
    // R2: empty list
    doCmd(C_CALL, 32'h8000_0101, 8'h00, 0, "R2 call-empty");
    doCmd(C_INT, 32'h0, 8'h33, 0, "R2 int-empty");
    // R7: no saved context
    doCmd(C_RET, 32'h0, 8'h00, 0, "R7 ret-noctx");
    // R1: setup
    cfgHead = 32'hABC0_0000 | 20'h1_0010; cfgLink = 32'h07C0_0000; cfgLimit = 32'h0000_0000 | 20'h1_0011;
    cmdValid = 1'b1; cmdOp = C_SETUP;
    @(negedge clk);
    cmdValid = 1'b0;
    mHead = cfgHead; mLink = cfgLink; mLimit = cfgLimit;
    chkEq("R1", "setup leaves idle", {31'b0, busy}, 32'h0);
    chkEq("R1", "setup head", headOut, mHead);
    chkEq("R1", "setup link", linkOut, mLink);
    doCmd(C_RFE, 32'h0, 8'h00, 0, "R7 rfe-noctx");
    // R4 R5: call
    fillRegs(2);
    doCmd(C_CALL, 32'h8000_1235, 8'h00, 0, "R5 call-1");
    // R6: second call takes the limit frame
    fillRegs(3);
    ackRandom = 1'b1;
    doCmd(C_CALL, 32'h9000_4567, 8'h00, 0, "R6 call-2");
    // R8 R10: return with commands injected while busy
    fillRegs(4);
    doCmd(C_RET, 32'h0, 8'h00, 1, "R8 ret-1");
    // R9: return-from-exception
    doCmd(C_RFE, 32'h0, 8'h00, 0, "R9 rfe-1");
    ackRandom = 1'b0;
    // R4 R5: interrupt entry saves lower bank
    fillRegs(5);
    doCmd(C_INT, 32'h0, 8'h42, 0, "R5 int-1");
    // R7: lower frame on top
    doCmd(C_RET, 32'h0, 8'h00, 0, "R7 ret-type");
    doCmd(C_RFE, 32'h0, 8'h00, 0, "R7 rfe-type");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end
endmodule